// File: doc/BRIEF.md
# Protection-Domain Data Access Checker

This block decides, for every data access a hardware thread makes, whether the page's protection domain lets the access go ahead. Each page that has been translated belongs to one of 16 domains. The domain number is held in a small, fully associative translation cache next to the physical page number. A per-thread rights word holds two control bits for each domain. On a lookup the block reads the cached domain, picks that domain's bits from the rights word, and compares them with the access kind. It returns allow, fault or miss, together with the physical page number.

Software changes rights by writing the rights word through a dedicated write port, and reads it back through a dedicated read port. No cache entry is touched when rights change, so updating a permission costs one register write. Cache entries are loaded from an external fill port. Instruction fetches always pass the check. The check is switched off entirely unless the wide-address mode input is high.

Top module: `pkey_access_checker`

## Requirements
- R1: After a synchronous active-high reset, `rsp_valid` is 0, the rights word reads 0, and every lookup returns miss.
- R2: A request presented with `req_valid` high at one rising edge produces `rsp_valid` high after that edge, for one cycle only. `rsp_valid` is never high except after a request. Result codes are 0 allow, 1 fault and 2 miss.
- R3: A lookup whose page number is not cached returns miss (code 2) with `rsp_ppn` equal to 0, and no key check is made.
- R4: A lookup that hits returns the physical page number stored by the fill, and returns allow when the domain's bits are clear.
- R5: The rights word gives domain n bit 2n as access-disable and bit 2n+1 as write-disable. Access-disable faults both loads (kind code 0) and stores (kind code 1).
- R6: Write-disable faults stores only. Loads to that domain are allowed. This holds for the lowest and the highest domain.
- R7: Instruction fetches (kind code 2; code 3 is treated the same) never fault, whatever the rights say.
- R8: While `long_mode` is low, no access faults, whatever the rights say. Misses still return miss.
- R9: A rights write at one edge governs a request presented at the next edge. Cached entries remain valid across rights writes.
- R10: `rights_rd_data` returns the last value written through the rights write port.
- R11: The cache holds 8 entries and fills new pages round-robin from slot 0. The ninth distinct page evicts the first one filled.
- R12: Filling a page number that is already cached updates that entry in place and does not move the replacement pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| long_mode | input | 1 | Enables domain checking when high |
| rights_wr_en | input | 1 | Write the rights word |
| rights_wr_data | input | 32 | New rights word |
| rights_rd_data | output | 32 | Current rights word |
| fill_en | input | 1 | Load a translation into the cache |
| fill_vpn | input | 20 | Virtual page number to fill |
| fill_ppn | input | 20 | Physical page number to fill |
| fill_domain | input | 4 | Protection domain of the filled page |
| req_valid | input | 1 | Access request strobe |
| req_kind | input | 2 | 0 load, 1 store, 2 or 3 fetch |
| req_vpn | input | 20 | Virtual page number of the access |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_result | output | 2 | 0 allow, 1 fault, 2 miss |
| rsp_ppn | output | 20 | Physical page number on a hit, else 0 |

## Verification
Loads, stores and fetches are sent to the same cached page under several rights words: all clear, access-disable only and write-disable only. This separates the kinds, because each word faults a different subset. Domains 0, 3, 4 and 15 are used so that a wrong bit offset lands on a neighbouring domain and shows up. Lowering `long_mode` with blocking bits set separates the mode gate from the key check. A rights write followed by a request on the very next cycle exposes an extra pipeline stage or an invalidated entry. Nine distinct fills, and a repeated fill inside eight, separate round-robin eviction from the in-place update.

// File: rtl/pkey_pkg.sv
package pkey_pkg;

    localparam int unsigned NUM_DOMAINS = 16;
    localparam int unsigned DOM_W       = $clog2(NUM_DOMAINS);
    localparam int unsigned RIGHTS_W    = 2 * NUM_DOMAINS;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        RES_ALLOW = 2'd0,
        RES_FAULT = 2'd1,
        RES_MISS  = 2'd2
    } acc_res_e;

    // Even bit of a domain pair blocks all data access, odd bit blocks writes.
    function automatic logic key_denies(
        input logic [RIGHTS_W-1:0] rights,
        input logic [DOM_W-1:0]    dom,
        input logic [1:0]          kind
    );
        logic blk_all;
        logic blk_wr;
        blk_all = rights[{dom, 1'b0}];
        blk_wr  = rights[{dom, 1'b1}];
        case (kind)
            2'(ACC_LOAD):  return blk_all;
            2'(ACC_STORE): return blk_all | blk_wr;
            default:       return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/key_rights_reg.sv
module key_rights_reg
    import pkey_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [RIGHTS_W-1:0] wr_data,
    output logic [RIGHTS_W-1:0] rights
);
    logic [RIGHTS_W-1:0] rights_q;

    always_ff @(posedge clk) begin
        if (rst)        rights_q <= '0;
        else if (wr_en) rights_q <= wr_data;
    end

    assign rights = rights_q;

    // R10: the word read back equals the one just written
    a_r10_readback: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rights == $past(wr_data));

endmodule

// File: rtl/key_tlb.sv
module key_tlb #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned VPN_W   = 20,
    parameter int unsigned PPN_W   = 20,
    parameter int unsigned DOM_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [DOM_W-1:0] fill_dom,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             look_hit,
    output logic [PPN_W-1:0] look_ppn,
    output logic [DOM_W-1:0] look_dom
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        logic [DOM_W-1:0] dom;
    } tlb_entry_t;

    tlb_entry_t         ent_q [ENTRIES];
    logic [IDX_W-1:0]   ptr_q;
    logic [ENTRIES-1:0] look_vec;
    logic [ENTRIES-1:0] fill_vec;
    logic [IDX_W-1:0]   fill_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign look_vec[g] = ent_q[g].valid && (ent_q[g].vpn == look_vpn);
        assign fill_vec[g] = ent_q[g].valid && (ent_q[g].vpn == fill_vpn);
    end

    assign look_hit = |look_vec;

    always_comb begin
        look_ppn = '0;
        look_dom = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (look_vec[i]) begin
                look_ppn |= ent_q[i].ppn;
                look_dom |= ent_q[i].dom;
            end
        end
    end

    always_comb begin
        fill_idx = ptr_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (fill_vec[i]) fill_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
            ptr_q <= '0;
        end else if (fill_en) begin
            ent_q[fill_idx] <= '{valid: 1'b1, vpn: fill_vpn, ppn: fill_ppn, dom: fill_dom};
            if (!(|fill_vec)) begin
                ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    // R12: in-place refill keeps page numbers unique, so at most one entry matches
    a_r12_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(look_vec));

    // R11: a fill of a new page always moves the replacement pointer on
    a_r11_ptr_moves: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !(|fill_vec)) |=> ptr_q != $past(ptr_q));

endmodule

// File: rtl/key_judge.sv
module key_judge
    import pkey_pkg::*;
(
    input  logic                long_mode,
    input  logic [1:0]          kind,
    input  logic [DOM_W-1:0]    dom,
    input  logic [RIGHTS_W-1:0] rights,
    output logic                fault
);
    assign fault = long_mode && key_denies(rights, dom, kind);

    // R7 and R8: fetches and the narrow mode never produce a fault
    always_comb begin
        a_r7_r8_exempt: assert (!(fault && (kind[1] || !long_mode)));
    end

endmodule

// File: rtl/pkey_access_checker.sv
module pkey_access_checker
    import pkey_pkg::*;
#(
    parameter int unsigned TLB_ENTRIES = 8,
    parameter int unsigned VPN_W       = 20,
    parameter int unsigned PPN_W       = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                long_mode,
    input  logic                rights_wr_en,
    input  logic [RIGHTS_W-1:0] rights_wr_data,
    output logic [RIGHTS_W-1:0] rights_rd_data,
    input  logic                fill_en,
    input  logic [VPN_W-1:0]    fill_vpn,
    input  logic [PPN_W-1:0]    fill_ppn,
    input  logic [DOM_W-1:0]    fill_domain,
    input  logic                req_valid,
    input  logic [1:0]          req_kind,
    input  logic [VPN_W-1:0]    req_vpn,
    output logic                rsp_valid,
    output logic [1:0]          rsp_result,
    output logic [PPN_W-1:0]    rsp_ppn
);
    logic [RIGHTS_W-1:0] rights;
    logic                look_hit;
    logic [PPN_W-1:0]    look_ppn;
    logic [DOM_W-1:0]    look_dom;
    logic                key_fault;

    logic                rsp_valid_q;
    acc_res_e            res_q;
    logic [PPN_W-1:0]    ppn_q;

    key_rights_reg u_rights (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (rights_wr_en),
        .wr_data (rights_wr_data),
        .rights  (rights)
    );

    key_tlb #(
        .ENTRIES (TLB_ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W),
        .DOM_W   (DOM_W)
    ) u_tlb (
        .clk      (clk),
        .rst      (rst),
        .fill_en  (fill_en),
        .fill_vpn (fill_vpn),
        .fill_ppn (fill_ppn),
        .fill_dom (fill_domain),
        .look_vpn (req_vpn),
        .look_hit (look_hit),
        .look_ppn (look_ppn),
        .look_dom (look_dom)
    );

    key_judge u_judge (
        .long_mode (long_mode),
        .kind      (req_kind),
        .dom       (look_dom),
        .rights    (rights),
        .fault     (key_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            res_q       <= RES_ALLOW;
            ppn_q       <= '0;
        end else begin
            rsp_valid_q <= req_valid;
            if (req_valid) begin
                if (!look_hit) begin
                    res_q <= RES_MISS;
                    ppn_q <= '0;
                end else begin
                    res_q <= key_fault ? RES_FAULT : RES_ALLOW;
                    ppn_q <= look_ppn;
                end
            end
        end
    end

    assign rights_rd_data = rights;
    assign rsp_valid      = rsp_valid_q;
    assign rsp_result     = res_q;
    assign rsp_ppn        = ppn_q;

    // R2: every request is answered on the following cycle
    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2: no response without a request
    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R7: a fetch is never answered with a fault
    a_r7_fetch_no_fault: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind[1]) |=> rsp_result != 2'(RES_FAULT));

    // R8: with the mode input low no fault is reported
    a_r8_mode_gate: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !long_mode) |=> rsp_result != 2'(RES_FAULT));

    // R3: a miss carries no page number
    a_r3_miss_no_ppn: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_result == 2'(RES_MISS)) |-> rsp_ppn == '0);

endmodule

// File: tb/pkey_access_checker_tb.sv
module pkey_access_checker_tb;

    localparam int CLK_PERIOD = 10;

    localparam logic [1:0] K_LOAD  = 2'd0;
    localparam logic [1:0] K_STORE = 2'd1;
    localparam logic [1:0] K_FETCH = 2'd2;
    localparam logic [1:0] R_ALLOW = 2'd0;
    localparam logic [1:0] R_FAULT = 2'd1;
    localparam logic [1:0] R_MISS  = 2'd2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        long_mode = 1'b0;
    logic        rights_wr_en = 1'b0;
    logic [31:0] rights_wr_data = '0;
    logic [31:0] rights_rd_data;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic [3:0]  fill_domain = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [19:0] req_vpn = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_result;
    logic [19:0] rsp_ppn;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pkey_access_checker u_dut (
        .clk            (clk),
        .rst            (rst),
        .long_mode      (long_mode),
        .rights_wr_en   (rights_wr_en),
        .rights_wr_data (rights_wr_data),
        .rights_rd_data (rights_rd_data),
        .fill_en        (fill_en),
        .fill_vpn       (fill_vpn),
        .fill_ppn       (fill_ppn),
        .fill_domain    (fill_domain),
        .req_valid      (req_valid),
        .req_kind       (req_kind),
        .req_vpn        (req_vpn),
        .rsp_valid      (rsp_valid),
        .rsp_result     (rsp_result),
        .rsp_ppn        (rsp_ppn)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [3:0] dom);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_domain = dom;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_rights(input logic [31:0] val);
        @(negedge clk);
        rights_wr_en = 1'b1; rights_wr_data = val;
        @(negedge clk);
        rights_wr_en = 1'b0;
    endtask

    // Request at one edge, response sampled on the following falling edge.
    task automatic do_access(input string tag, input logic [1:0] kind, input logic [19:0] vpn,
                             input logic [1:0] exp_res, input logic [19:0] exp_ppn);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_vpn = vpn;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " result"}, 32'(rsp_result), 32'(exp_res));
        check({tag, " ppn"}, 32'(rsp_ppn), 32'(exp_ppn));
    endtask

    task automatic t_reset();
        check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check("R1 rights after reset", rights_rd_data, 32'd0);
        long_mode = 1'b1;
        do_access("R1 empty cache vpn0", K_LOAD, 20'h0, R_MISS, 20'h0);
        do_access("R1 empty cache vpn5", K_STORE, 20'h5, R_MISS, 20'h0);
    endtask

    task automatic t_basic();
        do_fill(20'h10, 20'habc, 4'd3);
        do_access("R4 load hit", K_LOAD, 20'h10, R_ALLOW, 20'habc);
        do_access("R4 store hit", K_STORE, 20'h10, R_ALLOW, 20'habc);
        @(negedge clk);
        check("R2 one-cycle response", 32'(rsp_valid), 32'd0);
        do_access("R3 uncached page", K_LOAD, 20'h11, R_MISS, 20'h0);
    endtask

    task automatic t_access_disable();
        do_fill(20'h20, 20'h222, 4'd4);
        do_rights(32'h1 << 6);
        do_access("R5 AD load", K_LOAD, 20'h10, R_FAULT, 20'habc);
        do_access("R5 AD store", K_STORE, 20'h10, R_FAULT, 20'habc);
        do_access("R7 AD fetch", K_FETCH, 20'h10, R_ALLOW, 20'habc);
        do_access("R7 code3 fetch", 2'd3, 20'h10, R_ALLOW, 20'habc);
        do_access("R5 neighbour domain", K_LOAD, 20'h20, R_ALLOW, 20'h222);
        do_access("R3 miss not checked", K_LOAD, 20'h99, R_MISS, 20'h0);
    endtask

    task automatic t_write_disable();
        do_fill(20'h30, 20'h333, 4'd15);
        do_fill(20'h40, 20'h444, 4'd0);
        do_rights((32'h1 << 7) | (32'h1 << 31) | (32'h1 << 1));
        do_access("R6 WD load", K_LOAD, 20'h10, R_ALLOW, 20'habc);
        do_access("R6 WD store", K_STORE, 20'h10, R_FAULT, 20'habc);
        do_access("R6 dom15 load", K_LOAD, 20'h30, R_ALLOW, 20'h333);
        do_access("R6 dom15 store", K_STORE, 20'h30, R_FAULT, 20'h333);
        do_access("R6 dom0 store", K_STORE, 20'h40, R_FAULT, 20'h444);
        do_access("R6 dom4 store", K_STORE, 20'h20, R_ALLOW, 20'h222);
        do_access("R7 WD fetch", K_FETCH, 20'h30, R_ALLOW, 20'h333);
    endtask

    task automatic t_legacy();
        do_rights(32'hffff_ffff);
        long_mode = 1'b0;
        do_access("R8 load gated", K_LOAD, 20'h10, R_ALLOW, 20'habc);
        do_access("R8 store gated", K_STORE, 20'h30, R_ALLOW, 20'h333);
        do_access("R8 miss kept", K_LOAD, 20'h77, R_MISS, 20'h0);
        long_mode = 1'b1;
        do_access("R5 all blocked", K_LOAD, 20'h20, R_FAULT, 20'h222);
    endtask

    task automatic t_rights_immediate();
        do_rights(32'h0);
        @(negedge clk);
        rights_wr_en = 1'b1; rights_wr_data = 32'h1 << 6;
        @(negedge clk);
        rights_wr_en = 1'b0;
        req_valid = 1'b1; req_kind = K_LOAD; req_vpn = 20'h10;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 new rights next cycle", 32'(rsp_result), 32'(R_FAULT));
        @(negedge clk);
        rights_wr_en = 1'b1; rights_wr_data = 32'h0;
        @(negedge clk);
        rights_wr_en = 1'b0;
        req_valid = 1'b1; req_kind = K_STORE; req_vpn = 20'h10;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 entry kept after write", 32'(rsp_result), 32'(R_ALLOW));
        check("R9 entry ppn kept", 32'(rsp_ppn), 32'h abc);
    endtask

    task automatic t_rights_read();
        do_rights(32'hdead_beef);
        check("R10 readback a", rights_rd_data, 32'hdead_beef);
        do_rights(32'h1234_5678);
        check("R10 readback b", rights_rd_data, 32'h1234_5678);
    endtask

    task automatic t_round_robin();
        do_reset();
        do_rights(32'h0);
        for (int i = 0; i < 9; i++) do_fill(20'h100 + 20'(i), 20'h500 + 20'(i), 4'(i));
        do_access("R11 first evicted", K_LOAD, 20'h100, R_MISS, 20'h0);
        do_access("R11 second kept", K_LOAD, 20'h101, R_ALLOW, 20'h501);
        do_access("R11 last kept", K_LOAD, 20'h107, R_ALLOW, 20'h507);
        do_access("R11 ninth present", K_LOAD, 20'h108, R_ALLOW, 20'h508);
    endtask

    task automatic t_refill();
        do_reset();
        do_fill(20'h200, 20'h0aa, 4'd1);
        do_fill(20'h201, 20'h0bb, 4'd1);
        do_fill(20'h200, 20'h0cc, 4'd2);
        for (int i = 2; i < 8; i++) do_fill(20'h200 + 20'(i), 20'h600 + 20'(i), 4'd0);
        do_access("R12 updated in place", K_LOAD, 20'h200, R_ALLOW, 20'h0cc);
        do_access("R12 no eviction", K_LOAD, 20'h201, R_ALLOW, 20'h0bb);
        do_access("R12 eighth kept", K_LOAD, 20'h207, R_ALLOW, 20'h607);
        do_rights(32'h1 << 4);
        do_access("R12 new domain used", K_LOAD, 20'h200, R_FAULT, 20'h0cc);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_access_disable();
        t_write_disable();
        t_legacy();
        t_rights_immediate();
        t_rights_read();
        t_round_robin();
        t_refill();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule